// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block runs the control-flow operations of a small 8-bit processor over several clock cycles. It owns the 16-bit program counter and the 16-bit stack pointer. It carries out absolute and signed-relative jumps, calls, restarts to a short vector, plain returns and returns from interrupt. It also sets and clears the interrupt master enable. One clock cycle stands for one machine cycle, so each path costs its real number of machine cycles.

A decoder presents an operation code, a 16-bit operand and a condition qualifier together with a one-cycle `start` strobe. The flag unit supplies `cond_true_i`. While the sequence runs the block raises `busy_o` and uses a byte-wide stack memory port. That port has a combinational read and a write on the clock edge. The block pulses `done_o` when the operation completes. `cycles_o` holds the number of busy cycles the last operation used.

Top module: `flow_seq`

## Requirements
- R1: Codes 1 (jump) and 2 (relative jump) load PC only when taken. Taken means `cond_en_i`=0, or `cond_true_i`=1 at the start strobe. Codes 3 (call) and 4 (restart) follow the same rule. A not-taken operation leaves PC and SP unchanged and uses no busy cycle.
- R2: A taken call or restart pushes the PC it saw at start. The high byte is written to SP-1 in the first busy cycle and the low byte to SP-2 in the second. SP ends 2 lower, and PC is loaded in the third busy cycle.
- R3: Busy cycles per path: taken jump 1, taken call or restart 3, unconditional return 3, conditional return taken 4 or not taken 1, any not-taken branch 0. `cycles_o` shows this count after `done_o`.
- R4: The relative jump target is PC plus bits 7:0 of the operand, read as a two's-complement offset and sign-extended. PC wraps modulo 2^16.
- R5: The restart target is operand bits 7:0, zero-extended to 16 bits.
- R6: Code 5 (return) with `cond_en_i`=1 spends one wait cycle. `cond_true_i` is sampled at the end of that cycle. Code 5 with `cond_en_i`=0 does not wait. A taken return reads the low byte at SP, then the high byte at SP+1, one cycle each. It ends with PC = high:low and SP 2 higher.
- R7: Code 6 (return from interrupt) sets the interrupt master enable and then acts as an unconditional return. Code 7 clears the enable at no cycle cost.
- R8: `done_o` is high for exactly one cycle, the cycle after the last busy cycle. For a zero-cost operation it is the cycle after the start strobe. A start strobe while `busy_o` is high is ignored.
- R9: After reset PC is 0x0000, SP is 0xFFFE, the interrupt enable is 0, and `busy_o` and `done_o` are 0.
- R10: Code 0 completes with a `done_o` pulse. It changes nothing and uses no busy cycle. The stack port is never read and written in the same cycle, and it is idle while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation strobe, taken only when idle |
| op_i | input | 3 | Operation code (see R1, R6, R7, R10) |
| operand_i | input | 16 | Target address, relative offset or restart vector |
| cond_en_i | input | 1 | Operation is conditional |
| cond_true_i | input | 1 | Condition result from the flag unit |
| mem_rdata_i | input | 8 | Stack read data, valid in the read cycle |
| mem_we_o | output | 1 | Stack write strobe |
| mem_re_o | output | 1 | Stack read strobe |
| mem_addr_o | output | 16 | Stack byte address |
| mem_wdata_o | output | 8 | Stack write data |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| ime_o | output | 1 | Interrupt master enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | 4 | Busy cycles of the last operation |

## Verification
Some properties hold on every cycle, and the assertions check these. SP moves by one in the cycle after each stack write or read. The stack port never reads and writes together and is quiet when idle. PC changes only in the cycle `done_o` is high, and `done_o` never overlaps `busy_o`. The interrupt enable rises only during a busy sequence and falls only outside one. Other behaviours need known stimulus, so only the bench scenarios can show them: the branch targets, the byte order on the stack, the cycle cost of each path, the late sampling of the condition for a conditional return, and an ignored strobe in the middle of a call.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_JUMP = 3'd1,
    OP_JREL = 3'd2,
    OP_CALL = 3'd3,
    OP_RSTV = 3'd4,
    OP_RET  = 3'd5,
    OP_RETI = 3'd6,
    OP_DINT = 3'd7
  } flow_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CWAIT = 3'd1,
    ST_PUSHH = 3'd2,
    ST_PUSHL = 3'd3,
    ST_POPL  = 3'd4,
    ST_POPH  = 3'd5,
    ST_LOAD  = 3'd6
  } flow_st_e;
endpackage

// File: rtl/flow_target.sv
module flow_target
  import flow_pkg::*;
#(
  parameter int DW = 8
) (
  input  flow_op_e          op,
  input  logic [2*DW-1:0]   operand,
  input  logic [2*DW-1:0]   pc,
  output logic [2*DW-1:0]   target
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] rel_ext;
  logic [AW-1:0] vec_ext;

  assign rel_ext = {{(AW-DW){operand[DW-1]}}, operand[DW-1:0]};
  assign vec_ext = {{(AW-DW){1'b0}}, operand[DW-1:0]};

  always_comb begin
    case (op)
      OP_JREL: target = pc + rel_ext;
      OP_RSTV: target = vec_ext;
      default: target = operand;
    endcase
  end
endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  flow_op_e op,
  input  logic     cond_en,
  input  logic     cond_true,
  output flow_st_e state,
  output logic     accept,
  output logic     done
);
  flow_st_e state_nx;
  logic     done_nx;
  logic     taken;

  assign accept = start && (state == ST_IDLE);
  assign taken  = !cond_en || cond_true;

  always_comb begin
    state_nx = state;
    done_nx  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          case (op)
            OP_JUMP, OP_JREL: state_nx = taken ? ST_LOAD : ST_IDLE;
            OP_CALL, OP_RSTV: state_nx = taken ? ST_PUSHH : ST_IDLE;
            OP_RET:           state_nx = cond_en ? ST_CWAIT : ST_POPL;
            OP_RETI:          state_nx = ST_POPL;
            default:          state_nx = ST_IDLE;
          endcase
          done_nx = (state_nx == ST_IDLE);
        end
      end
      ST_CWAIT: begin
        state_nx = cond_true ? ST_POPL : ST_IDLE;
        done_nx  = !cond_true;
      end
      ST_PUSHH: state_nx = ST_PUSHL;
      ST_PUSHL: state_nx = ST_LOAD;
      ST_POPL:  state_nx = ST_POPH;
      ST_POPH:  state_nx = ST_LOAD;
      ST_LOAD: begin
        state_nx = ST_IDLE;
        done_nx  = 1'b1;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= done_nx;
    end
  end
endmodule

// File: rtl/flow_stack.sv
module flow_stack
  import flow_pkg::*;
#(
  parameter int              DW     = 8,
  parameter logic [2*DW-1:0] SP_RST = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  flow_st_e        state,
  input  logic [2*DW-1:0] pc,
  input  logic [DW-1:0]   rdata,
  output logic [2*DW-1:0] sp,
  output logic            we,
  output logic            re,
  output logic [2*DW-1:0] addr,
  output logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] pop_word
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] sp_nx;
  logic          sp_en;
  logic [DW-1:0] lo_q, hi_q;
  logic          lo_en, hi_en;
  logic [AW-1:0] sp_dec;

  assign sp_dec = sp - {{(AW-1){1'b0}}, 1'b1};
  assign we     = (state == ST_PUSHH) || (state == ST_PUSHL);
  assign re     = (state == ST_POPL) || (state == ST_POPH);
  assign addr   = we ? sp_dec : sp;
  assign wdata  = (state == ST_PUSHH) ? pc[AW-1:DW] : pc[DW-1:0];
  assign lo_en  = (state == ST_POPL);
  assign hi_en  = (state == ST_POPH);
  assign pop_word = {hi_q, lo_q};

  always_comb begin
    sp_en = we || re;
    sp_nx = we ? sp_dec : (sp + {{(AW-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp   <= SP_RST;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (sp_en) sp   <= sp_nx;
      if (lo_en) lo_q <= rdata;
      if (hi_en) hi_q <= rdata;
    end
  end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          CW     = 4,
  parameter logic [15:0] PC_RST = 16'h0000,
  parameter logic [15:0] SP_RST = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [15:0]   operand_i,
  input  logic          cond_en_i,
  input  logic          cond_true_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [15:0]   mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic [15:0]   pc_o,
  output logic [15:0]   sp_o,
  output logic          ime_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [3:0]    cycles_o
);
  localparam int AW = 2 * DW;

  flow_op_e      op;
  flow_st_e      state;
  logic          accept;
  logic [AW-1:0] target;
  logic [AW-1:0] target_q;
  logic          from_stack_q;
  logic [AW-1:0] pop_word;
  logic [AW-1:0] pc_q, pc_nx;
  logic          pc_en;
  logic          ime_q, ime_nx, ime_en;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;
  logic          busy;

  assign op   = flow_op_e'(op_i);
  assign busy = (state != ST_IDLE);

  flow_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .op        (op),
    .cond_en   (cond_en_i),
    .cond_true (cond_true_i),
    .state     (state),
    .accept    (accept),
    .done      (done_o)
  );

  flow_target #(.DW(DW)) u_target (
    .op      (op),
    .operand (operand_i),
    .pc      (pc_q),
    .target  (target)
  );

  flow_stack #(.DW(DW), .SP_RST(SP_RST)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .pc       (pc_q),
    .rdata    (mem_rdata_i),
    .sp       (sp_o),
    .we       (mem_we_o),
    .re       (mem_re_o),
    .addr     (mem_addr_o),
    .wdata    (mem_wdata_o),
    .pop_word (pop_word)
  );

  always_comb begin
    pc_en  = (state == ST_LOAD);
    pc_nx  = from_stack_q ? pop_word : target_q;
    ime_en = accept && ((op == OP_RETI) || (op == OP_DINT));
    ime_nx = (op == OP_RETI);
    cnt_en = accept || busy;
    cnt_nx = accept ? '0 : (cnt_q + {{(CW-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q         <= PC_RST;
      target_q     <= '0;
      from_stack_q <= 1'b0;
      ime_q        <= 1'b0;
      cnt_q        <= '0;
    end else begin
      if (accept) begin
        target_q     <= target;
        from_stack_q <= (op == OP_RET) || (op == OP_RETI);
      end
      if (pc_en)  pc_q  <= pc_nx;
      if (ime_en) ime_q <= ime_nx;
      if (cnt_en) cnt_q <= cnt_nx;
    end
  end

  assign pc_o     = pc_q;
  assign ime_o    = ime_q;
  assign busy_o   = busy;
  assign cycles_o = cnt_q;
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic [15:0] sp_o,
  input logic [15:0] pc_o,
  input logic        ime_o,
  input logic        busy_o,
  input logic        done_o
);
  AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (sp_o == $past(sp_o) - 16'd1)); // R2

  AST_POP_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> (sp_o == $past(sp_o) + 16'd1)); // R6

  AST_PC_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o != $past(pc_o)) |-> done_o); // R1

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o); // R8

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R10

  AST_PORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !mem_re_o)); // R10

  AST_IME_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ime_o) |-> busy_o); // R7

  AST_IME_FALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ime_o) |-> !busy_o); // R7
endmodule

bind flow_seq flow_seq_chk u_flow_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_we_o (mem_we_o),
  .mem_re_o (mem_re_o),
  .sp_o     (sp_o),
  .pc_o     (pc_o),
  .ime_o    (ime_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/flow_seq_bench.sv
`timescale 1ns/1ps
module flow_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [15:0] operand_i = 16'h0;
  logic        cond_en_i = 1'b0;
  logic        cond_true_i = 1'b0;
  logic [7:0]  mem_rdata_i;
  logic        mem_we_o, mem_re_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [15:0] pc_o, sp_o;
  logic        ime_o, busy_o, done_o;
  logic [3:0]  cycles_o;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [0:255];
  logic [15:0] m_pc = 16'h0000;
  logic [15:0] m_sp = 16'hFFFE;
  logic        m_ime = 1'b0;

  always #5 clk = ~clk;

  flow_seq u_flow_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .operand_i(operand_i), .cond_en_i(cond_en_i), .cond_true_i(cond_true_i),
    .mem_rdata_i(mem_rdata_i), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .pc_o(pc_o),
    .sp_o(sp_o), .ime_o(ime_o), .busy_o(busy_o), .done_o(done_o),
    .cycles_o(cycles_o)
  );

  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  always @(posedge clk) if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_cost(input logic [2:0] op, input logic cen, input logic tk);
    case (op)
      3'd1, 3'd2: return tk ? 1 : 0;
      3'd3, 3'd4: return tk ? 3 : 0;
      3'd5:       return cen ? (tk ? 4 : 1) : 3;
      3'd6:       return 3;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [15:0] exp_target(input logic [2:0] op, input logic [15:0] opd,
                                             input logic [15:0] pc);
    case (op)
      3'd2:    return pc + {{8{opd[7]}}, opd[7:0]};
      3'd4:    return {8'h00, opd[7:0]};
      default: return opd;
    endcase
  endfunction

  // Called at a falling edge; returns at the falling edge where done_o is high.
  task automatic run_op(input logic [2:0] op, input logic [15:0] opd, input logic cen,
                        input logic ct, input bit poke);
    logic        tk;
    int          n;
    int          cost;
    logic [15:0] old_pc;
    logic [7:0]  lo, hi;
    tk     = (op == 3'd6) || !cen || ct;
    cost   = exp_cost(op, cen, tk);
    old_pc = m_pc;
    if (op == 3'd5 || op == 3'd6) begin
      lo = 8'($urandom);
      hi = 8'($urandom);
      mem[m_sp[7:0]] = lo;
      mem[8'(m_sp[7:0] + 8'd1)] = hi;
    end else begin
      lo = 8'h0;
      hi = 8'h0;
    end
    start_i = 1'b1; op_i = op; operand_i = opd; cond_en_i = cen; cond_true_i = ct;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 40) begin
      n++;
      if (poke && n == 1) begin
        start_i = 1'b1; op_i = 3'd1; operand_i = 16'h1234; cond_en_i = 1'b0;
      end else if (poke && n == 2) begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    case (op)
      3'd1, 3'd2: if (tk) m_pc = exp_target(op, opd, old_pc);
      3'd3, 3'd4: if (tk) begin
        m_pc = exp_target(op, opd, old_pc);
        m_sp = m_sp - 16'd2;
      end
      3'd5, 3'd6: begin
        if (op == 3'd6) m_ime = 1'b1;
        if (tk) begin
          m_pc = {hi, lo};
          m_sp = m_sp + 16'd2;
        end
      end
      3'd7: m_ime = 1'b0;
      default: ;
    endcase
    chk("R8 done pulse", 32'(done_o), 32'd1);
    chk("R3 busy cycles", 32'(n), 32'(cost));
    chk("R3 cycles_o", 32'(cycles_o), 32'(cost));
    chk("R1 pc", 32'(pc_o), 32'(m_pc));
    chk("R2 sp", 32'(sp_o), 32'(m_sp));
    chk("R7 ime", 32'(ime_o), 32'(m_ime));
    if ((op == 3'd3 || op == 3'd4) && tk) begin
      chk("R2 pushed high byte", 32'(mem[8'(m_sp[7:0] + 8'd1)]), 32'(old_pc[15:8]));
      chk("R2 pushed low byte", 32'(mem[m_sp[7:0]]), 32'(old_pc[7:0]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset pc", 32'(pc_o), 32'h0000);
    chk("R9 reset sp", 32'(sp_o), 32'hFFFE);
    chk("R9 reset ime", 32'(ime_o), 32'd0);
    chk("R9 reset busy", 32'(busy_o), 32'd0);
    chk("R9 reset done", 32'(done_o), 32'd0);

    run_op(3'd0, 16'hBEEF, 1'b0, 1'b0, 1'b0);              // R10 nop
    run_op(3'd6, 16'h0000, 1'b0, 1'b0, 1'b0);              // R7 reti sets ime
    run_op(3'd7, 16'h0000, 1'b0, 1'b0, 1'b0);              // R7 disable clears ime
    run_op(3'd1, 16'h4000, 1'b1, 1'b1, 1'b0);              // R1 jump taken
    run_op(3'd1, 16'h5555, 1'b1, 1'b0, 1'b0);              // R1 jump not taken
    run_op(3'd2, 16'h0080, 1'b0, 1'b0, 1'b0);              // R4 offset -128
    run_op(3'd2, 16'h007F, 1'b0, 1'b0, 1'b0);              // R4 offset +127
    run_op(3'd3, 16'h8123, 1'b0, 1'b0, 1'b1);              // R2 R8 call with ignored strobe
    chk("R8 ignored strobe left pc", 32'(pc_o), 32'h8123);
    run_op(3'd4, 16'hAB38, 1'b1, 1'b1, 1'b0);              // R5 restart vector
    run_op(3'd3, 16'h9000, 1'b1, 1'b0, 1'b0);              // R1 call not taken
    run_op(3'd5, 16'h0000, 1'b1, 1'b0, 1'b0);              // R6 cond return not taken
    run_op(3'd5, 16'h0000, 1'b1, 1'b1, 1'b0);              // R6 cond return taken
    run_op(3'd5, 16'h0000, 1'b0, 1'b0, 1'b0);              // R6 plain return
    run_op(3'd1, 16'hFFF0, 1'b0, 1'b0, 1'b0);
    run_op(3'd2, 16'h0020, 1'b0, 1'b0, 1'b0);              // R4 wrap past 0xFFFF

    for (int k = 0; k < 300; k++) begin
      run_op(3'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    end

    @(negedge clk);
    chk("R8 done one cycle", 32'(done_o), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule